// File: doc/BRIEF.md
# Picture-in-picture control register slave

This block is the two-wire serial slave that configures a picture-in-picture overlay core. A bus master writes one setting at a time: it sends the slave address with the write direction, then a register index, then one data byte. The slave stores the byte, with the bits that have no function cleared, and the overlay core reads every field in parallel from dedicated output pins. These fields cover window position, size, border colour, freeze, enable, blanking, reference polarity, test select, colour trims and delays.

Reads carry no index. A read addressed to the slave returns a status byte built from two core inputs. The first shows whether a write the core was commanded to make is still pending. The second shows whether the inset's sync has been lost. SCL and SDA pass through a two-flop synchroniser on the system clock. The slave drives SDA only through an open-drain enable. It never holds SCL low.

Top module: `pip_ctrl_regs`

## Requirements
- R1: The slave answers only to the 7-bit address 0x12. That is the byte 0x24 for a write and 0x25 for a read. An address byte with any other 7-bit address is not acknowledged, and nothing that follows it changes any register until the next start condition.
- R2: In a write, the slave acknowledges the address byte, the index byte and the data byte. The data byte is stored in the register at that index, and all other registers keep their values.
- R3: Field positions in the data byte. Index 0: wpos=D2..D0, rpos=D7..D4. Index 1: sw_delay=D3..D0, vfilt_en=D4. Index 2: border=D2..D0. Index 3: test_sel=D2..D0, vpol_neg=D6, hpol_neg=D7. Index 4: freeze=D4, size_ninth=D5 (0 selects a 1/16 window, 1 a 1/9 window), yc_mode=D6, cv_src=D7. Index 5: pip_on=D0, blank=D4. Indices 6 to 9: xpos, ypos, chroma and tint in D5..D0. Index 10: luma_dly=D2..D0. Bits outside these fields are discarded.
- R4: A write to an index from 11 to 255 is acknowledged in full and changes no register.
- R5: A read returns the byte {wr_busy, 5'b0, sync_lost, 1'b0}, with D7 first on the wire. If the master acknowledges, the same byte is sent again. If the master does not acknowledge, the slave releases SDA until the next start condition.
- R6: A repeated start ends the current transaction and begins a new one. This holds even after an address that did not match.
- R7: A synchronous reset clears every register field to zero and releases SDA.
- R8: Once a transaction's data byte is stored, further bytes in it are not acknowledged and not stored. After a stop condition, bytes clocked without a new start are ignored and SDA is released.
- R9: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_busy | input | 1 | Core write still pending (status D7) |
| sync_lost | input | 1 | Inset sync absent (status D1) |
| wpos | output | 3 | Inset raster start trim |
| rpos | output | 4 | Main clamp gate trim |
| sw_delay | output | 4 | Overlay switch delay |
| vfilt_en | output | 1 | Vertical filter enable |
| border | output | 3 | Border colour code |
| test_sel | output | 3 | Test pin select |
| vpol_neg | output | 1 | Vertical reference active on falling edge |
| hpol_neg | output | 1 | Horizontal reference active on falling edge |
| freeze | output | 1 | Hold the last stored field |
| size_ninth | output | 1 | 1 = 1/9 window, 0 = 1/16 window |
| yc_mode | output | 1 | Separate luma/chroma input select |
| cv_src | output | 1 | Composite source select |
| pip_on | output | 1 | Overlay enable |
| blank | output | 1 | Force the overlay to black |
| xpos | output | 6 | Horizontal window position |
| ypos | output | 6 | Vertical window position |
| chroma | output | 6 | Inset colour saturation |
| tint | output | 6 | Inset tint |
| luma_dly | output | 3 | Luma-to-chroma delay |

## Verification
Each bus pin change reaches the state machine on the second rising clock edge after it and takes effect on the third. A stored field therefore appears three clock edges after the SCL rise of the data byte's last bit. SDA drive changes three edges after an SCL fall. The bench holds each SCL phase for 16 clocks. It samples the acknowledge and read bits in the middle of the SCL high phase, well after the drive has settled. It compares the fields only after the stop condition, when every update is long complete.

// File: rtl/pip_regs_pkg.sv
package pip_regs_pkg;

    localparam int NUM_REGS   = 11;
    localparam int BYTE_W     = 8;
    localparam logic [6:0] SLAVE_ADDR = 7'h12;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_PREACK,
        ST_ACK, ST_READ, ST_MACK, ST_RELOAD, ST_WAIT
    } xfer_state_e;

    typedef struct packed {
        xfer_state_e        st;
        xfer_state_e        after;
        logic [2:0]         cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  sub;
        logic               oe;
    } engine_t;

    // Live bits of each register; all others read back as zero.
    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'hF7;
            1:       return 8'h1F;
            2:       return 8'h07;
            3:       return 8'hC7;
            4:       return 8'hF0;
            5:       return 8'h11;
            6, 7, 8, 9: return 8'h3F;
            10:      return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pip_i2c_sync.sv
module pip_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_d, scl_q, sda_d, sda_q;
    logic             scl_prev, sda_prev;

    always_comb begin
        scl_d = {scl_q[DEPTH-2:0], scl_in};
        sda_d = {sda_q[DEPTH-2:0], sda_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_s    = scl_q[STAGES-1];
    assign sda_s    = sda_q[STAGES-1];
    assign scl_prev = scl_q[STAGES];
    assign sda_prev = sda_q[STAGES];

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & ~sda_s & sda_prev;
    assign stop_det  = scl_s & scl_prev & sda_s & ~sda_prev;

endmodule

// File: rtl/pip_i2c_engine.sv
module pip_i2c_engine
    import pip_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_sub,
    output logic [BYTE_W-1:0] wr_data
);
    engine_t q, d;

    always_comb begin
        d       = q;
        wr_stb  = 1'b0;
        wr_sub  = q.sub;
        wr_data = {q.sh[BYTE_W-2:0], sda_s};

        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (scl_rise) begin
            if (q.st == ST_ADDR || q.st == ST_SUB || q.st == ST_DATA) begin
                d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                d.cnt = q.cnt + 3'd1;
                if (q.cnt == 3'd7) begin
                    d.st = ST_PREACK;
                    if (q.st == ST_ADDR) begin
                        if (d.sh[7:1] == SLAVE_ADDR)
                            d.after = d.sh[0] ? ST_READ : ST_SUB;
                        else
                            d.st = ST_WAIT;
                    end else if (q.st == ST_SUB) begin
                        d.sub   = d.sh;
                        d.after = ST_DATA;
                    end else begin
                        wr_stb  = 1'b1;
                        d.after = ST_WAIT;
                    end
                end
            end else if (q.st == ST_MACK) begin
                d.st = sda_s ? ST_WAIT : ST_RELOAD;
            end
        end else if (scl_fall) begin
            unique case (q.st)
                ST_PREACK: begin
                    d.oe = 1'b1;
                    d.st = ST_ACK;
                end
                ST_ACK, ST_RELOAD: begin
                    d.oe  = 1'b0;
                    d.cnt = '0;
                    d.st  = (q.st == ST_RELOAD) ? ST_READ : q.after;
                    if (d.st == ST_READ) begin
                        d.sh = status;
                        d.oe = ~status[7];
                    end
                end
                ST_READ: begin
                    if (q.cnt == 3'd7) begin
                        d.oe = 1'b0;
                        d.st = ST_MACK;
                    end else begin
                        d.cnt = q.cnt + 3'd1;
                        d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                        d.oe  = ~q.sh[BYTE_W-2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= ST_IDLE;
            q.after <= ST_IDLE;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.sub   <= '0;
            q.oe    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

endmodule

// File: rtl/pip_reg_bank.sv
module pip_reg_bank
    import pip_regs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_stb,
    input  logic [BYTE_W-1:0]          wr_sub,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] MASK = reg_mask(i);

        always_comb begin
            regs_d[i] = regs_q[i];
            if (wr_stb && wr_sub == BYTE_W'(i))
                regs_d[i] = wr_data & MASK;
        end

        always_ff @(posedge clk) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end

        assign regs_flat[i*BYTE_W +: BYTE_W] = regs_q[i];
    end

endmodule

// File: rtl/pip_ctrl_regs.sv
module pip_ctrl_regs
    import pip_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       wr_busy,
    input  logic       sync_lost,
    output logic [2:0] wpos,
    output logic [3:0] rpos,
    output logic [3:0] sw_delay,
    output logic       vfilt_en,
    output logic [2:0] border,
    output logic [2:0] test_sel,
    output logic       vpol_neg,
    output logic       hpol_neg,
    output logic       freeze,
    output logic       size_ninth,
    output logic       yc_mode,
    output logic       cv_src,
    output logic       pip_on,
    output logic       blank,
    output logic [5:0] xpos,
    output logic [5:0] ypos,
    output logic [5:0] chroma,
    output logic [5:0] tint,
    output logic [2:0] luma_dly
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_stb;
    logic [BYTE_W-1:0] wr_sub, wr_data, status;
    logic [NUM_REGS*BYTE_W-1:0] reg_flat;

    assign status = {wr_busy, 5'b0, sync_lost, 1'b0};

    pip_i2c_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    pip_i2c_engine u_engine (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .status(status), .sda_oe(sda_oe), .wr_stb(wr_stb),
        .wr_sub(wr_sub), .wr_data(wr_data)
    );

    pip_reg_bank u_bank (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_sub(wr_sub),
        .wr_data(wr_data), .regs_flat(reg_flat)
    );

    assign wpos       = reg_flat[0*8 + 0 +: 3];
    assign rpos       = reg_flat[0*8 + 4 +: 4];
    assign sw_delay   = reg_flat[1*8 + 0 +: 4];
    assign vfilt_en   = reg_flat[1*8 + 4];
    assign border     = reg_flat[2*8 + 0 +: 3];
    assign test_sel   = reg_flat[3*8 + 0 +: 3];
    assign vpol_neg   = reg_flat[3*8 + 6];
    assign hpol_neg   = reg_flat[3*8 + 7];
    assign freeze     = reg_flat[4*8 + 4];
    assign size_ninth = reg_flat[4*8 + 5];
    assign yc_mode    = reg_flat[4*8 + 6];
    assign cv_src     = reg_flat[4*8 + 7];
    assign pip_on     = reg_flat[5*8 + 0];
    assign blank      = reg_flat[5*8 + 4];
    assign xpos       = reg_flat[6*8 + 0 +: 6];
    assign ypos       = reg_flat[7*8 + 0 +: 6];
    assign chroma     = reg_flat[8*8 + 0 +: 6];
    assign tint       = reg_flat[9*8 + 0 +: 6];
    assign luma_dly   = reg_flat[10*8 + 0 +: 3];

endmodule

// File: rtl/pip_ctrl_regs_chk.sv
module pip_ctrl_regs_chk
    import pip_regs_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       scl_s,
    input logic                       stop_det,
    input logic                       sda_oe,
    input logic                       wr_stb,
    input logic [BYTE_W-1:0]          wr_sub,
    input logic [NUM_REGS*BYTE_W-1:0] reg_flat
);
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_flat == '0 && !sda_oe));

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(reg_flat));

    assert_undef_index_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_sub >= BYTE_W'(NUM_REGS)) |=> $stable(reg_flat));

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    assert_drive_on_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

endmodule

bind pip_ctrl_regs pip_ctrl_regs_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_sub(wr_sub), .reg_flat(reg_flat)
);

// File: tb/pip_ctrl_regs_test.sv
`timescale 1ns/1ps
module pip_ctrl_regs_test;
    localparam int H = 16;
    localparam int NREG = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wr_busy = 1'b0, sync_lost = 1'b0;
    logic sda_oe, sda_line;
    logic [2:0] wpos, border, test_sel, luma_dly;
    logic [3:0] rpos, sw_delay;
    logic vfilt_en, vpol_neg, hpol_neg, freeze, size_ninth, yc_mode, cv_src, pip_on, blank;
    logic [5:0] xpos, ypos, chroma, tint;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_reg [NREG];

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    pip_ctrl_regs uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .wr_busy(wr_busy), .sync_lost(sync_lost),
        .wpos(wpos), .rpos(rpos), .sw_delay(sw_delay), .vfilt_en(vfilt_en),
        .border(border), .test_sel(test_sel), .vpol_neg(vpol_neg), .hpol_neg(hpol_neg),
        .freeze(freeze), .size_ninth(size_ninth), .yc_mode(yc_mode), .cv_src(cv_src),
        .pip_on(pip_on), .blank(blank), .xpos(xpos), .ypos(ypos), .chroma(chroma),
        .tint(tint), .luma_dly(luma_dly)
    );

    function automatic logic [7:0] live_bits(input int idx);
        case (idx)
            0: return 8'b1111_0111;
            1: return 8'b0001_1111;
            2: return 8'b0000_0111;
            3: return 8'b1100_0111;
            4: return 8'b1111_0000;
            5: return 8'b0001_0001;
            10: return 8'b0000_0111;
            default: return 8'b0011_1111;
        endcase
    endfunction

    function automatic logic [7:0] observed(input int idx);
        case (idx)
            0: return {rpos, 1'b0, wpos};
            1: return {3'b0, vfilt_en, sw_delay};
            2: return {5'b0, border};
            3: return {hpol_neg, vpol_neg, 3'b0, test_sel};
            4: return {cv_src, yc_mode, size_ninth, freeze, 4'b0};
            5: return {3'b0, blank, 3'b0, pip_on};
            6: return {2'b0, xpos};
            7: return {2'b0, ypos};
            8: return {2'b0, chroma};
            9: return {2'b0, tint};
            default: return {5'b0, luma_dly};
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, got, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            check(observed(i) == exp_reg[i], req, $sformatf("reg %0d", i),
                  observed(i), exp_reg[i]);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic i2c_rstart;
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H/2);
        acked = ~sda_line;
        tick(H/2);
        scl_m = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, input bit master_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H/2);
            b[i] = sda_line;
            tick(H/2);
            scl_m = 1'b0;
        end
        sda_m = ~master_ack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] sub, input logic [7:0] val, input string req);
        bit a0, a1, a2;
        i2c_start;
        put_byte(8'h24, a0);
        put_byte(sub, a1);
        put_byte(val, a2);
        i2c_stop;
        tick(4);
        check(a0, req, "address ack", {7'b0, a0}, 8'h01);
        check(a1, req, "index ack", {7'b0, a1}, 8'h01);
        check(a2, req, "data ack", {7'b0, a2}, 8'h01);
        if (sub < NREG) exp_reg[sub] = val & live_bits(int'(sub));
        check_regs(req);
    endtask

    task automatic read_status(input string req);
        bit a;
        logic [7:0] b0, b1, e;
        e = {wr_busy, 5'b0, sync_lost, 1'b0};
        i2c_start;
        put_byte(8'h25, a);
        check(a, req, "read address ack", {7'b0, a}, 8'h01);
        get_byte(b0, 1'b1);
        get_byte(b1, 1'b0);
        check(b0 == e, req, "status byte", b0, e);
        check(b1 == e, req, "repeated status byte", b1, e);
        i2c_stop;
        tick(4);
        check(sda_oe == 1'b0, "R5", "release after nack", {7'b0, sda_oe}, 8'h00);
    endtask

    initial begin
        bit a;
        logic [7:0] vals [4];
        logic [7:0] rd;
        vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'h5A; vals[3] = 8'hA5;
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(5);
        // R7: reset state of every field and of the SDA drive
        check_regs("R7");
        check(sda_oe == 1'b0, "R7", "sda released", {7'b0, sda_oe}, 8'h00);

        // R2, R3: sweep every register with several patterns
        for (int s = 0; s < NREG; s++)
            for (int v = 0; v < 4; v++)
                write_reg(8'(s), vals[v], (v == 1) ? "R3" : "R2");

        // R4: undefined indices are acknowledged and discarded
        write_reg(8'h0B, 8'hFF, "R4");
        write_reg(8'h0F, 8'h3C, "R4");
        write_reg(8'h80, 8'h55, "R4");
        write_reg(8'hFF, 8'hFF, "R4");

        // R1: wrong addresses get no ack and change nothing
        i2c_start;
        put_byte(8'h26, a);
        check(!a, "R1", "foreign address nack", {7'b0, a}, 8'h00);
        put_byte(8'h06, a);
        put_byte(8'h00, a);
        i2c_stop;
        tick(4);
        check_regs("R1");
        i2c_start;
        put_byte(8'hA4, a);
        check(!a, "R1", "high-bit address nack", {7'b0, a}, 8'h00);
        i2c_stop;

        // R8: extra byte after data is refused and not stored
        i2c_start;
        put_byte(8'h24, a);
        put_byte(8'h07, a);
        put_byte(8'h15, a);
        put_byte(8'h2A, a);
        check(!a, "R8", "extra byte nack", {7'b0, a}, 8'h00);
        i2c_stop;
        tick(4);
        exp_reg[7] = 8'h15;
        check_regs("R8");

        // R8: bytes clocked after a stop without a start are ignored
        put_byte(8'h24, a);
        check(!a, "R8", "no ack without start", {7'b0, a}, 8'h00);
        put_byte(8'h06, a);
        put_byte(8'h01, a);
        i2c_stop;
        tick(4);
        check_regs("R8");

        // R6: repeated start after a foreign address starts a fresh write
        i2c_start;
        put_byte(8'h30, a);
        i2c_rstart;
        put_byte(8'h24, a);
        check(a, "R6", "ack after repeated start", {7'b0, a}, 8'h01);
        put_byte(8'h09, a);
        put_byte(8'h2B, a);
        i2c_stop;
        tick(4);
        exp_reg[9] = 8'h2B;
        check_regs("R6");

        // R6: write index then repeated start into a read
        i2c_start;
        put_byte(8'h24, a);
        put_byte(8'h06, a);
        i2c_rstart;
        put_byte(8'h25, a);
        check(a, "R6", "read after repeated start", {7'b0, a}, 8'h01);
        get_byte(rd, 1'b0);
        check(rd == 8'h00, "R6", "status via repeated start", rd, 8'h00);
        i2c_stop;
        tick(4);
        check_regs("R6");

        // R5: status byte for every flag combination
        for (int c = 0; c < 4; c++) begin
            wr_busy = c[1];
            sync_lost = c[0];
            read_status("R5");
        end
        check_regs("R5");

        // R7: a later reset clears written fields
        rst = 1'b1; tick(2); rst = 1'b0; tick(2);
        for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
        check_regs("R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule